// File: doc/BRIEF.md
# Crosspoint Serial Shift Controller

This block is the serial programming front end for an 8x8 video crosspoint. A 32-bit shift register holds eight 4-bit per-output control fields. Bits enter at the least significant end on each qualified rising edge of a write strobe. The most significant bit leaves on a serial output, so a second controller can be chained behind the first. All inputs are sampled on the system clock. A strobe edge counts when the strobe is high in one cycle and was low in the cycle before.

A latch input moves the shifted word into the active per-output state. A mode strap selects when this happens. In edge mode the word transfers on a rising edge of the latch. In level mode it transfers on every cycle in which the latch is low. During a transfer, each output reads its own field as a command: route an input, ground, enable or disable. Serial programming has no command that acts on all outputs at once. The active state drives, for each output, a 3-bit input select, a ground flag and an enable. The analog matrix reads these three signals.

Top module: `xp_serial_ctrl`

## Requirements
- R1: The word shifts left by one and takes `serIn` as its new bit 0 only at a clock edge where `wrStrobe` is 1, `wrStrobe` was 0 one cycle earlier, `chipSelN` is 0 and `chipSel` is 1. If any of these conditions fails, the word does not change.
- R2: The field of output k is word bits [31-4k:28-4k]. After 32 shifts, the first bit shifted in is bit 3 of output 0 and the last four bits shifted in are the field of output 7.
- R3: Four further shifts move every field one output lower, so output 0 takes the field that output 1 held before.
- R4: `serOut` always equals word bit 31.
- R5: With `edgeSel`=1, the active state changes only at an edge where `latchIn` is 1 and was 0 one cycle earlier. If a qualified strobe edge falls at the same edge, the transfer uses the word as it was before that shift.
- R6: With `edgeSel`=0, a transfer happens at every edge where `latchIn` is 0. A bit shifted at one edge therefore reaches the active state at the next edge.
- R7: After reset, the word is zero and every output has enable 0, ground flag 0 and select 0.
- R8: In a transfer, code 9 sets enable 1 and ground flag 1 and clears the select to 0, which drops the previous routing. Code 10 sets enable 0 and leaves the ground flag and the select as they were.
- R9: In a transfer to an output that is already enabled, codes 0 to 7 clear the ground flag and set the select to that code. Code 8 sets the ground flag and clears the select. For a disabled output, codes 0 to 8 change nothing.
- R10: Codes 11 to 15 leave the output unchanged. A field acts only on its own output, so no single code changes all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Write strobe; a rising edge shifts in one bit |
| chipSelN | input | 1 | Chip enable, active low |
| chipSel | input | 1 | Chip enable, active high |
| serIn | input | 1 | Serial data input |
| latchIn | input | 1 | Transfer control |
| edgeSel | input | 1 | 1: transfer on latch rising edge; 0: transfer while latch low |
| serOut | output | 1 | Serial data output (word MSB) for chaining |
| routeSel | output | 24 | Input select of output k at bits [3k+2:3k] |
| routeGnd | output | 8 | Ground flag for each output |
| routeEn | output | 8 | Enable for each output |

## Verification
In edge mode, a qualified strobe edge and a latch rising edge can fall on the same clock edge, so a shift and a transfer occur together. The bench raises the strobe and the latch in the same cycle, with the shift bit chosen to change the affected field. It then compares the active state with the pre-shift word, and `serOut` with the post-shift word. In level mode, every shift is followed by a transfer on the next cycle. The bench checks the active state after each single shift, including the cycle in which a field passes through code 9 on its way to another code.

// File: rtl/xp_serial_pkg.sv
package xp_serial_pkg;

  // Strobes from the control to the datapath, valid for one clock.
  typedef struct packed {
    logic shiftEn;  // qualified write-strobe edge: shift one bit in
    logic applyEn;  // transfer the word into the active state
  } xpStrobe_t;

endpackage

// File: rtl/xp_serial_ctl.sv
module xp_serial_ctl
  import xp_serial_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrStrobe,
  input  logic      chipSelN,
  input  logic      chipSel,
  input  logic      latchIn,
  input  logic      edgeSel,
  output xpStrobe_t strobe
);

  // Previous-cycle copies. They reset high, so an input that is already
  // high when reset ends does not count as an edge.
  logic wrQ;
  logic latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ    <= 1'b1;
      latchQ <= 1'b1;
    end else begin
      wrQ    <= wrStrobe;
      latchQ <= latchIn;
    end
  end

  logic chipOn;
  logic wrRise;
  logic latchRise;

  always_comb begin
    chipOn    = chipSel & ~chipSelN;
    wrRise    = wrStrobe & ~wrQ;
    latchRise = latchIn & ~latchQ;
    strobe.shiftEn = wrRise & chipOn;
    strobe.applyEn = edgeSel ? latchRise : ~latchIn;
  end

endmodule

// File: rtl/xp_serial_path.sv
module xp_serial_path
  import xp_serial_pkg::*;
#(
  parameter int NOUT   = 8,
  parameter int FIELDW = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xpStrobe_t                     strobe,
  input  logic                          serIn,
  output logic                          serOut,
  output logic [NOUT*$clog2(NOUT)-1:0]  routeSel,
  output logic [NOUT-1:0]               routeGnd,
  output logic [NOUT-1:0]               routeEn
);

  localparam int SELW  = $clog2(NOUT);
  localparam int WORDW = NOUT * FIELDW;
  // Code values: 0..NOUT-1 route an input, then ground, enable, disable.
  localparam logic [FIELDW-1:0] CODE_GND = FIELDW'(NOUT);
  localparam logic [FIELDW-1:0] CODE_EN  = FIELDW'(NOUT + 1);
  localparam logic [FIELDW-1:0] CODE_DIS = FIELDW'(NOUT + 2);

  logic [WORDW-1:0] wordQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
    end else if (strobe.shiftEn) begin
      wordQ <= {wordQ[WORDW-2:0], serIn};
    end
  end

  assign serOut = wordQ[WORDW-1];

  // One decoder and state slice per output. Output 0 owns the top field.
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [FIELDW-1:0] code;
    logic              enQ;
    logic              gndQ;
    logic [SELW-1:0]   selQ;

    assign code = wordQ[(NOUT-1-k)*FIELDW +: FIELDW];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ  <= 1'b0;
        gndQ <= 1'b0;
        selQ <= '0;
      end else if (strobe.applyEn) begin
        if (code == CODE_EN) begin
          enQ  <= 1'b1;
          gndQ <= 1'b1;
          selQ <= '0;
        end else if (code == CODE_DIS) begin
          enQ  <= 1'b0;
        end else if (enQ) begin
          if (code < CODE_GND) begin
            gndQ <= 1'b0;
            selQ <= code[SELW-1:0];
          end else if (code == CODE_GND) begin
            gndQ <= 1'b1;
            selQ <= '0;
          end
        end
      end
    end

    assign routeEn[k]                = enQ;
    assign routeGnd[k]               = gndQ;
    assign routeSel[k*SELW +: SELW]  = selQ;
  end

endmodule

// File: rtl/xp_serial_ctrl.sv
module xp_serial_ctrl
  import xp_serial_pkg::*;
#(
  parameter int NOUT   = 8,
  parameter int FIELDW = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrStrobe,
  input  logic                          chipSelN,
  input  logic                          chipSel,
  input  logic                          serIn,
  input  logic                          latchIn,
  input  logic                          edgeSel,
  output logic                          serOut,
  output logic [NOUT*$clog2(NOUT)-1:0]  routeSel,
  output logic [NOUT-1:0]               routeGnd,
  output logic [NOUT-1:0]               routeEn
);

  xpStrobe_t strobe;

  xp_serial_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .chipSelN (chipSelN),
    .chipSel  (chipSel),
    .latchIn  (latchIn),
    .edgeSel  (edgeSel),
    .strobe   (strobe)
  );

  xp_serial_path #(.NOUT(NOUT), .FIELDW(FIELDW)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .serIn    (serIn),
    .serOut   (serOut),
    .routeSel (routeSel),
    .routeGnd (routeGnd),
    .routeEn  (routeEn)
  );

endmodule

// File: rtl/xp_serial_chk.sv
module xp_serial_chk #(
  parameter int NOUT = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrStrobe,
  input logic                          chipSelN,
  input logic                          chipSel,
  input logic                          latchIn,
  input logic                          edgeSel,
  input logic                          serOut,
  input logic [NOUT*$clog2(NOUT)-1:0]  routeSel,
  input logic [NOUT-1:0]               routeGnd,
  input logic [NOUT-1:0]               routeEn
);

  localparam int SELW = $clog2(NOUT);

  logic wrSeen;
  logic latchSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen    <= 1'b1;
      latchSeen <= 1'b1;
    end else begin
      wrSeen    <= wrStrobe;
      latchSeen <= latchIn;
    end
  end

  // R4: without a qualified strobe edge the chain output holds.
  a_r4_serout_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && !wrSeen && !chipSelN && chipSel) |=> $stable(serOut));

  // R5 / R6: when no transfer is due, the active state holds.
  a_r5_no_transfer_hold: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSel ? !(latchIn && !latchSeen) : latchIn)
      |=> ($stable(routeEn) && $stable(routeGnd) && $stable(routeSel)));

  for (genvar k = 0; k < NOUT; k++) begin : g_chk
    // R8: an output that becomes enabled is grounded with select 0.
    a_r8_enable_grounds: assert property (@(posedge clk) disable iff (!rstN)
      $rose(routeEn[k]) |-> (routeGnd[k] && routeSel[k*SELW +: SELW] == '0));

    // R9: a disabled output keeps its routing unless it is being enabled.
    a_r9_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
      !routeEn[k] |=> (routeEn[k] ||
        ($stable(routeGnd[k]) && $stable(routeSel[k*SELW +: SELW]))));
  end

endmodule

bind xp_serial_ctrl xp_serial_chk #(.NOUT(NOUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrStrobe (wrStrobe),
  .chipSelN (chipSelN),
  .chipSel  (chipSel),
  .latchIn  (latchIn),
  .edgeSel  (edgeSel),
  .serOut   (serOut),
  .routeSel (routeSel),
  .routeGnd (routeGnd),
  .routeEn  (routeEn)
);

// File: tb/xp_serial_ctrl_bench.sv
module xp_serial_ctrl_bench;

  localparam int NOUT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wr = 1'b0, csN = 1'b0, cs = 1'b1, sIn = 1'b0, lat = 1'b0, edgeM = 1'b1;
  logic serOut;
  logic [23:0] routeSel;
  logic [7:0]  routeGnd, routeEn;

  always #2 clk = ~clk;

  xp_serial_ctrl u_xp_serial_ctrl (
    .clk(clk), .rstN(rstN), .wrStrobe(wr), .chipSelN(csN), .chipSel(cs),
    .serIn(sIn), .latchIn(lat), .edgeSel(edgeM), .serOut(serOut),
    .routeSel(routeSel), .routeGnd(routeGnd), .routeEn(routeEn)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference state, derived from the requirements.
  logic [31:0] mWord = '0;
  logic [7:0]  mEn = '0, mGnd = '0;
  logic [23:0] mSel = '0;
  logic        mWrQ = 1'b1, mLatQ = 1'b1;

  task automatic applyWord(input logic [31:0] w);
    for (int k = 0; k < NOUT; k++) begin
      int c;
      c = int'(w[(7-k)*4 +: 4]);
      if (c == 9) begin
        mEn[k] = 1'b1; mGnd[k] = 1'b1; mSel[k*3 +: 3] = 3'd0;
      end else if (c == 10) begin
        mEn[k] = 1'b0;
      end else if (mEn[k] && c < 8) begin
        mGnd[k] = 1'b0; mSel[k*3 +: 3] = 3'(c);
      end else if (mEn[k] && c == 8) begin
        mGnd[k] = 1'b1; mSel[k*3 +: 3] = 3'd0;
      end
    end
  endtask

  // One clock: update the reference from current inputs, then advance.
  task automatic step();
    bit wrRise, doApply;
    wrRise  = wr && !mWrQ && !csN && cs;
    doApply = edgeM ? (lat && !mLatQ) : !lat;
    if (doApply) applyWord(mWord);
    if (wrRise) mWord = {mWord[30:0], sIn};
    mWrQ = wr; mLatQ = lat;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag);
    checks++;
    if (serOut !== mWord[31] || routeEn !== mEn || routeGnd !== mGnd ||
        routeSel !== mSel) begin
      failures++;
      $display("FAIL %s: en=%h gnd=%h sel=%h so=%b expected en=%h gnd=%h sel=%h so=%b",
               tag, routeEn, routeGnd, routeSel, serOut, mEn, mGnd, mSel, mWord[31]);
    end
  endtask

  task automatic shiftBit(input logic b);
    sIn = b; wr = 1'b1; step();
    wr = 1'b0; step();
  endtask

  task automatic shiftWord(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic latchPulse();
    lat = 1'b1; step();
    lat = 1'b0; step();
  endtask

  function automatic logic [31:0] mk(input int c0, c1, c2, c3, c4, c5, c6, c7);
    int c[8];
    logic [31:0] w;
    c = '{c0, c1, c2, c3, c4, c5, c6, c7};
    w = '0;
    for (int k = 0; k < 8; k++) w[(7-k)*4 +: 4] = 4'(c[k]);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R7 reset state");
    rstN = 1'b1;
    step();
    check("R7 after reset release");

    // R8: enable all but output 3, which receives disable.
    shiftWord(mk(9, 9, 9, 10, 9, 9, 9, 9));
    check("R5 shifted without latch edge");
    latchPulse();
    check("R8 enable grounds, R2 field order");

    // R9: route on enabled outputs, with one ground code and one disabled output.
    shiftWord(mk(3, 7, 8, 5, 0, 1, 6, 2));
    latchPulse();
    check("R9 routing on enabled outputs, disabled output 3 unchanged");

    // R8/R9/R10 sweep: every code on every output, others re-enabled each time.
    for (int k = 0; k < 8; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] w;
        w = mk(4, 4, 4, 4, 4, 4, 4, 4);
        w[(7-k)*4 +: 4] = 4'(c);
        shiftWord(w);
        latchPulse();
        check($sformatf("R10 R9 R8 sweep out%0d code%0d", k, c));
      end
      shiftWord(mk(9, 9, 9, 9, 9, 9, 9, 9));
      latchPulse();
      check($sformatf("R8 re-enable after out%0d sweep", k));
    end

    // R3: an extra group moves fields one output down.
    shiftWord(mk(0, 1, 2, 3, 4, 5, 6, 7));
    for (int i = 0; i < 4; i++) shiftBit((4'd8 >> (3 - i)) & 1'b1);
    latchPulse();
    check("R3 extra group shifts fields");

    // R1: strobe edges with either chip enable inactive do not shift.
    csN = 1'b1;
    for (int i = 0; i < 8; i++) shiftBit(~mWord[31]);
    check("R1 chipSelN high blocks shift");
    csN = 1'b0; cs = 1'b0;
    for (int i = 0; i < 8; i++) shiftBit(~mWord[31]);
    latchPulse();
    check("R1 chipSel low blocks shift");
    cs = 1'b1;
    // R1: strobe held high for several cycles shifts once.
    sIn = 1'b1; wr = 1'b1; step(); step(); step();
    wr = 1'b0; step();
    check("R1 R4 held strobe shifts once");

    // R5: strobe and latch edges together transfer the pre-shift word.
    shiftWord(mk(9, 9, 9, 9, 9, 9, 9, 1));
    latchPulse();
    shiftWord(mk(2, 2, 2, 2, 2, 2, 2, 3));
    sIn = 1'b0; wr = 1'b1; lat = 1'b1; step();
    check("R5 coincident strobe and latch edges");
    wr = 1'b0; lat = 1'b0; step();
    latchPulse();
    check("R5 later latch applies shifted word");

    // R6: level mode with latch low, each shift shows one cycle later.
    edgeM = 1'b0; lat = 1'b1; step();
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = mk(10, 9, 3, 8, 9, 0, 10, 5);
      lat = 1'b0;
      shiftBit(w[31 - i]);
      check($sformatf("R6 level mode after shift %0d", i));
    end
    // R6: latch high in level mode holds the active state.
    lat = 1'b1; step();
    shiftWord(mk(10, 10, 10, 10, 10, 10, 10, 10));
    check("R6 level mode latch high holds");
    lat = 1'b0; step();
    check("R6 level mode latch low transfers");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule